// File: doc/BRIEF.md
# Parity-Protected Bus Transceiver

This block joins an 8-bit data bus (side A) to a 9-bit bus (side B) that carries the same 8 data bits plus one parity bit. Each side is modelled the way a tri-state pin is built inside a chip: a data-out vector plus a drive-enable that says whether the block owns the wires. Traffic heading from A to B gets a freshly computed odd-parity bit attached. Traffic heading from B to A is passed through unchanged. At the same time, its 9 bits are checked, and the check result is captured into a clocked error flag.

Two active-low enables choose the operating mode. With neither enable asserted, both sides are released. With one asserted, the direction follows the side being driven. With both asserted, the block does not fight itself on the wires. It drives A to B with the parity bit deliberately inverted, so that a downstream checker can be tested against a known fault. Data always passes in true (non-inverted) form.

The error flag has an asynchronous active-low clear that overrides the clock. It is presented on an active-low error pin. The block has no flow control: it is a combinational path plus one flag register, and the enables are its only control.

Top module: `bus_parity_xcvr`

## Requirements
- R1: With `a_oe_n`=1 and `b_oe_n`=1 (isolate), both `a_drive` and `b_drive` are 0.
- R2: With `a_oe_n`=1 and `b_oe_n`=0 (A to B), `b_drive`=1, `a_drive`=0 and `b_out[7:0]` equals `a_in` bit for bit.
- R3: In the A-to-B mode, `b_out[8]` is the parity bit, chosen so that the 9 bits of `b_out` hold an odd number of ones.
- R4: With `a_oe_n`=0 and `b_oe_n`=0 (forced fault), `b_drive`=1, `a_drive`=0 and `b_out[7:0]` equals `a_in`. `b_out[8]` is inverted, so `b_out` holds an even number of ones.
- R5: With `a_oe_n`=0 and `b_oe_n`=1 (B to A), `a_drive`=1, `b_drive`=0 and `a_out` equals `b_in[7:0]`. Here `b_in[8]` is the received parity bit.
- R6: In the B-to-A mode, each rising `clk` edge with `clr_n`=1 loads the flag from the parity check. After that edge, `err_n` is 0 if `b_in` held an even number of ones and 1 if it held an odd number.
- R7: In every mode other than B to A, a rising `clk` edge with `clr_n`=1 loads the no-error state, so `err_n` reads 1.
- R8: While `clr_n` is 0, `err_n` is 1. This takes effect without a clock edge and holds through any clock edges for as long as `clr_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error flag |
| clr_n | input | 1 | Asynchronous clear of the error flag, active low |
| a_oe_n | input | 1 | Enable for the A-side drivers, active low |
| b_oe_n | input | 1 | Enable for the B-side drivers, active low |
| a_in | input | 8 | Data seen on the A bus |
| a_out | output | 8 | Data the block drives onto the A bus |
| a_drive | output | 1 | The block owns the A bus |
| b_in | input | 9 | Word seen on the B bus, bit 8 is parity |
| b_out | output | 9 | Word the block drives onto the B bus, bit 8 is parity |
| b_drive | output | 1 | The block owns the B bus |
| err_n | output | 1 | Registered parity error flag, active low |

## Verification
Two functions can meet at the same clock edge: the flag capturing a bad B word, and the clear. The bench provokes this by holding `clr_n` low across several rising edges while `b_in` carries a single-bit error in the B-to-A mode. It judges the result by checking that `err_n` stays 1 on every one of those edges. Once `clr_n` is released, the next edge must capture the error, which shows that the clear was masking a live error condition. The bench also changes mode between a captured error and the next edge, to show that leaving the B-to-A mode loads the no-error state on that edge.

// File: rtl/bus_parity_xcvr_pkg.sv
package bus_parity_xcvr_pkg;

  typedef enum logic [1:0] {
    MODE_ISOLATE = 2'b00,
    MODE_A2B     = 2'b01,
    MODE_B2A     = 2'b10,
    MODE_FAULT   = 2'b11
  } xcvr_mode_e;

  function automatic xcvr_mode_e decode_mode(input logic a_oe_n, input logic b_oe_n);
    case ({a_oe_n, b_oe_n})
      2'b11:   return MODE_ISOLATE;
      2'b10:   return MODE_A2B;
      2'b01:   return MODE_B2A;
      default: return MODE_FAULT;
    endcase
  endfunction

endpackage

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import bus_parity_xcvr_pkg::*;
(
  input  logic       a_oe_n,
  input  logic       b_oe_n,
  output xcvr_mode_e mode,
  output logic       drive_a,
  output logic       drive_b,
  output logic       invert_par,
  output logic       check_en
);

  always_comb begin
    mode       = decode_mode(a_oe_n, b_oe_n);
    drive_a    = 1'b0;
    drive_b    = 1'b0;
    invert_par = 1'b0;
    check_en   = 1'b0;
    unique case (mode)
      MODE_A2B: drive_b = 1'b1;
      MODE_FAULT: begin
        drive_b    = 1'b1;
        invert_par = 1'b1;
      end
      MODE_B2A: begin
        drive_a  = 1'b1;
        check_en = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/odd_parity_gen.sv
module odd_parity_gen #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data,
  input  logic             invert,
  output logic             par_bit
);

  localparam int STAGES = WIDTH;

  // Ripple XOR chain built bit by bit, then folded into an odd-parity bit.
  logic [STAGES:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < STAGES; i++) begin : g_xor
    assign chain[i+1] = chain[i] ^ data[i];
  end

  // Odd parity: the extra bit is set when the data already has an even count.
  assign par_bit = ~chain[STAGES] ^ invert;

endmodule

// File: rtl/parity_checker.sv
module parity_checker #(
  parameter int WIDTH = 9
) (
  input  logic [WIDTH-1:0] word,
  input  logic             enable,
  output logic             bad
);

  logic ones_odd;
  assign ones_odd = ^word;
  assign bad      = enable & ~ones_odd;

endmodule

// File: rtl/err_flag_reg.sv
module err_flag_reg (
  input  logic clk,
  input  logic clr_n,
  input  logic bad_in,
  output logic flag_q
);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) flag_q <= 1'b0;
    else        flag_q <= bad_in;
  end

endmodule

// File: rtl/bus_parity_xcvr.sv
module bus_parity_xcvr
  import bus_parity_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              a_oe_n,
  input  logic              b_oe_n,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_drive,
  input  logic [DATA_W:0]   b_in,
  output logic [DATA_W:0]   b_out,
  output logic              b_drive,
  output logic              err_n
);

  localparam int WORD_W = DATA_W + 1;

  xcvr_mode_e mode;
  logic       invert_par, check_en, par_bit, bad, flag_q;

  xcvr_mode_ctrl u_mode (
    .a_oe_n     (a_oe_n),
    .b_oe_n     (b_oe_n),
    .mode       (mode),
    .drive_a    (a_drive),
    .drive_b    (b_drive),
    .invert_par (invert_par),
    .check_en   (check_en)
  );

  odd_parity_gen #(.WIDTH(DATA_W)) u_gen (
    .data    (a_in),
    .invert  (invert_par),
    .par_bit (par_bit)
  );

  parity_checker #(.WIDTH(WORD_W)) u_chk (
    .word   (b_in),
    .enable (check_en),
    .bad    (bad)
  );

  err_flag_reg u_flag (
    .clk    (clk),
    .clr_n  (clr_n),
    .bad_in (bad),
    .flag_q (flag_q)
  );

  // Outputs always carry true data; drive-enables say who owns each bus.
  assign b_out = {par_bit, a_in};
  assign a_out = b_in[DATA_W-1:0];
  assign err_n = ~flag_q;

endmodule

// File: rtl/bus_parity_xcvr_checker.sv
module bus_parity_xcvr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              clr_n,
  input logic              a_oe_n,
  input logic              b_oe_n,
  input logic [DATA_W-1:0] a_in,
  input logic [DATA_W-1:0] a_out,
  input logic              a_drive,
  input logic [DATA_W:0]   b_in,
  input logic [DATA_W:0]   b_out,
  input logic              b_drive,
  input logic              err_n
);

  assert_isolate_R1: assert property (@(posedge clk)
    (a_oe_n && b_oe_n) |-> (!a_drive && !b_drive));

  assert_single_owner_R1: assert property (@(posedge clk)
    $onehot0({a_drive, b_drive}));

  assert_a2b_data_R2: assert property (@(posedge clk)
    b_drive |-> (b_out[DATA_W-1:0] == a_in));

  assert_odd_parity_R3: assert property (@(posedge clk)
    (a_oe_n && !b_oe_n) |-> (b_drive && ^b_out));

  assert_forced_even_R4: assert property (@(posedge clk)
    (!a_oe_n && !b_oe_n) |-> (b_drive && !(^b_out)));

  assert_b2a_data_R5: assert property (@(posedge clk)
    a_drive |-> (a_out == b_in[DATA_W-1:0] && !a_oe_n && b_oe_n));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (!a_oe_n && b_oe_n) |=> (err_n == $past(^b_in)));

  assert_other_modes_R7: assert property (@(posedge clk) disable iff (!clr_n)
    !(!a_oe_n && b_oe_n) |=> err_n);

  assert_clear_R8: assert property (@(posedge clk)
    !clr_n |-> err_n);

endmodule

bind bus_parity_xcvr bus_parity_xcvr_checker #(.DATA_W(DATA_W)) u_checker (
  .clk     (clk),
  .clr_n   (clr_n),
  .a_oe_n  (a_oe_n),
  .b_oe_n  (b_oe_n),
  .a_in    (a_in),
  .a_out   (a_out),
  .a_drive (a_drive),
  .b_in    (b_in),
  .b_out   (b_out),
  .b_drive (b_drive),
  .err_n   (err_n)
);

// File: tb/bus_parity_xcvr_tb_top.sv
module bus_parity_xcvr_tb_top;

  logic       clk = 1'b0;
  logic       clr_n, a_oe_n, b_oe_n;
  logic [7:0] a_in, a_out;
  logic [8:0] b_in, b_out;
  logic       a_drive, b_drive, err_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  bus_parity_xcvr dut_i (
    .clk(clk), .clr_n(clr_n), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive), .err_n(err_n)
  );

  function automatic int ones(input logic [8:0] v);
    int c = 0;
    for (int i = 0; i < 9; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic an, input logic bn);
    @(negedge clk);
    a_oe_n = an;
    b_oe_n = bn;
  endtask

  task automatic t_reset;
    clr_n = 1'b0; a_oe_n = 1'b1; b_oe_n = 1'b1; a_in = '0; b_in = '0;
    repeat (3) @(posedge clk);
    #1 check(err_n === 1'b1, "R8 reset", int'(err_n), 1);
    @(negedge clk) clr_n = 1'b1;
  endtask

  task automatic t_isolate;
    set_mode(1'b1, 1'b1);
    for (int v = 0; v < 256; v += 37) begin
      a_in = 8'(v); b_in = 9'(v * 3);
      #1 check({a_drive, b_drive} == 2'b00, "R1 isolate", int'({a_drive, b_drive}), 0);
    end
    @(posedge clk) #1 check(err_n === 1'b1, "R7 isolate flag", int'(err_n), 1);
  endtask

  task automatic t_a2b;
    set_mode(1'b1, 1'b0);
    for (int v = 0; v < 256; v++) begin
      a_in = 8'(v);
      #1;
      check(b_drive && !a_drive && b_out[7:0] == 8'(v), "R2 a2b data",
            int'({a_drive, b_drive, b_out[7:0]}), int'({2'b01, 8'(v)}));
      check(ones(b_out) % 2 == 1, "R3 odd parity", int'(b_out[8]),
            int'(ones({1'b0, 8'(v)}) % 2 == 0));
    end
  endtask

  task automatic t_fault;
    set_mode(1'b0, 1'b0);
    for (int v = 0; v < 256; v++) begin
      a_in = 8'(v);
      #1;
      check(b_drive && !a_drive && b_out[7:0] == 8'(v), "R4 fault data",
            int'({a_drive, b_drive, b_out[7:0]}), int'({2'b01, 8'(v)}));
      check(ones(b_out) % 2 == 0, "R4 inverted parity", int'(b_out[8]),
            int'(ones({1'b0, 8'(v)}) % 2 == 1));
    end
    @(posedge clk) #1 check(err_n === 1'b1, "R7 fault flag", int'(err_n), 1);
  endtask

  task automatic t_b2a;
    set_mode(1'b0, 1'b1);
    for (int v = 0; v < 256; v++) begin
      logic [8:0] w;
      w = {~(^8'(v)), 8'(v)};
      @(negedge clk) b_in = w;
      #1 check(a_drive && !b_drive && a_out == 8'(v), "R5 b2a data",
               int'({a_drive, b_drive, a_out}), int'({2'b10, 8'(v)}));
      @(posedge clk) #1 check(err_n === 1'b1, "R6 good word", int'(err_n), 1);
      @(negedge clk) b_in = w ^ (9'd1 << (v % 9));
      @(posedge clk) #1 check(err_n === 1'b0, "R6 single-bit error", int'(err_n), 0);
    end
  endtask

  task automatic t_leave_b2a;
    set_mode(1'b0, 1'b1);
    b_in = 9'h000;
    @(posedge clk) #1 check(err_n === 1'b0, "R6 even word", int'(err_n), 0);
    set_mode(1'b1, 1'b0);
    @(posedge clk) #1 check(err_n === 1'b1, "R7 leave b2a", int'(err_n), 1);
  endtask

  task automatic t_clear;
    set_mode(1'b0, 1'b1);
    b_in = 9'h003;
    @(posedge clk) #1 check(err_n === 1'b0, "R6 before clear", int'(err_n), 0);
    @(negedge clk) clr_n = 1'b0;
    #1 check(err_n === 1'b1, "R8 async clear", int'(err_n), 1);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk) #1 check(err_n === 1'b1, "R8 clear over clock", int'(err_n), 1);
    end
    @(negedge clk) clr_n = 1'b1;
    #1 check(err_n === 1'b1, "R8 released", int'(err_n), 1);
    @(posedge clk) #1 check(err_n === 1'b0, "R6 recapture", int'(err_n), 0);
  endtask

  initial begin
    t_reset();
    t_isolate();
    t_a2b();
    t_fault();
    t_b2a();
    t_leave_b2a();
    t_clear();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule